// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control for a successive-approximation converter whose sample stage has two phases. A start pulse, accepted only while the block is idle, captures an input channel number, a 5-bit sample-time value and a 3-bit resolution select. The block then drives three mutually exclusive sample-path enables. The buffered path is on for two clock cycles. The direct path is on for the rest of the programmed sample time. Hold is on for the whole bit search.

During hold the block runs the binary search one bit per cycle, starting at the most significant bit. It presents each trial code to an external capacitor DAC and reads back one comparator bit. When the last bit has been decided, the result is stored left-aligned in a 12-bit register and a one-cycle done pulse marks it. The analog switches, the DAC and the comparator are outside this block.

Top module: `sar_conv_seq`

## Requirements
- R1: A start request seen while idle captures the channel, sample time and resolution select. In the next cycle busy is high and the buffered-path enable is on.
- R2: The buffered-path enable is on for exactly two consecutive cycles at the beginning of every conversion.
- R3: The direct-path enable follows the buffered phase and lasts N-2 cycles. N is the captured 5-bit sample time, and any value below 4 counts as 4.
- R4: At most one of buffered, direct and hold is on in any cycle, and they occur in that order within a conversion.
- R5: Resolution select 0 gives 8 bits, 1 gives 10 bits, and any other value gives 12 bits. Hold lasts one cycle per bit. The first trial code is 0x800 (bit 11 alone), and done follows N+R cycles after the start edge.
- R6: A trial bit stays set when the comparator is 1 (input at or above the trial level) and is cleared otherwise. Outside hold the trial code is zero. During hold, no bit below the resolution's lowest bit is ever set.
- R7: The result is left-aligned in 12 bits, with the bits below the resolution's lowest bit equal to zero. It is valid when done is high, and done is high for one cycle only.
- R8: Busy stays high from the cycle after an accepted start until the done cycle, in which it is low. A start request made while busy has no effect on timing, channel or result, and no second conversion follows it.
- R9: The channel output holds the captured channel for the whole conversion, even if the channel input changes.
- R10: While the synchronous active-low reset is asserted, all of the following are zero or low: busy, done, the three enables, the trial code and the result. This holds even if reset arrives in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted only when idle |
| chan_i | input | 4 | Requested input channel |
| smp_time_i | input | 5 | Total sample time in cycles (min 4) |
| res_sel_i | input | 3 | Resolution select: 0=8, 1=10, other=12 bits |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial level |
| busy_o | output | 1 | Conversion in progress |
| chan_o | output | 4 | Channel held for the input multiplexer |
| buf_en_o | output | 1 | Buffered sample path enable |
| direct_en_o | output | 1 | Direct sample path enable |
| hold_o | output | 1 | Hold, input disconnected, search running |
| dac_code_o | output | 12 | Trial code to the capacitor DAC |
| result_o | output | 12 | Left-aligned conversion result |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
A new start request and an ongoing conversion can occur in the same cycle. If the request were not gated, it would restart the sample phase or replace the captured channel and configuration. The bench provokes this by raising start during the direct phase, with a different channel, sample time and resolution. The conversion is judged correct only if its phase lengths, held channel and result still match the first request, and busy stays low in the cycle after done.

// File: rtl/sar_seq_pkg.sv
// Shared types and helpers for the SAR conversion sequencer.
// Assumes a 3-bit resolution select passed in an 8-bit container.
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUF    = 2'd1,
        PH_DIRECT = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    // Map the resolution select to a bit count: 0->8, 1->10, else 12.
    function automatic int res_to_bits(input logic [7:0] sel);
        case (sel)
            8'd0:    return 8;
            8'd1:    return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
// Phase controller: idle, buffered sample, direct sample, conversion.
// Captures channel, sample time and resolution on an accepted start.
// Assumes BUF_CYC < MIN_SMP so the direct phase is never empty.
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int SMP_W   = 5,
    parameter int RES_W   = 3,
    parameter int CH_W    = 4,
    parameter int BUF_CYC = 2,
    parameter int MIN_SMP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             last_i,
    output phase_e           phase_o,
    output logic             busy_o,
    output logic [CH_W-1:0]  chan_o,
    output logic [RES_W-1:0] res_o
);

    phase_e            phase_q;
    logic [SMP_W-1:0]  cnt_q;
    logic [SMP_W-1:0]  dir_last_q;
    logic [CH_W-1:0]   chan_q;
    logic [RES_W-1:0]  res_q;
    logic [SMP_W-1:0]  smp_eff;

    // Clamp short sample times to the minimum.
    always_comb begin
        smp_eff = (smp_i < SMP_W'(MIN_SMP)) ? SMP_W'(MIN_SMP) : smp_i;
    end

    // Phase sequencing and capture of the conversion setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            dir_last_q <= '0;
            chan_q     <= '0;
            res_q      <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q    <= PH_BUF;
                        cnt_q      <= '0;
                        chan_q     <= chan_i;
                        res_q      <= res_i;
                        dir_last_q <= smp_eff - SMP_W'(BUF_CYC + 1);
                    end
                end
                PH_BUF: begin
                    if (cnt_q == SMP_W'(BUF_CYC - 1)) begin
                        phase_q <= PH_DIRECT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DIRECT: begin
                    if (cnt_q == dir_last_q) begin
                        phase_q <= PH_CONV;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (last_i) begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign busy_o  = (phase_q != PH_IDLE);
    assign chan_o  = chan_q;
    assign res_o   = res_q;

    AST_BUF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BUF && $past(phase_q) == PH_IDLE) |=> (phase_q == PH_BUF)); // R2
    AST_BUF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BUF && $past(phase_q) == PH_BUF) |=> (phase_q == PH_DIRECT)); // R2
    AST_DIRECT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DIRECT && $past(phase_q) == PH_BUF) |=> (phase_q == PH_DIRECT)); // R3
    AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(chan_o)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && phase_q != PH_CONV) |=> busy_o); // R8

endmodule

// File: rtl/sar_search.sv
// Successive-approximation register: one bit per cycle, MSB first.
// Reloads the MSB-only trial code whenever the conversion phase is off.
// Assumes res_i stays stable during the conversion phase.
module sar_search
    import sar_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int RES_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] dac_o,
    output logic [DATA_W-1:0] code_o,
    output logic              last_o
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] TOP_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] sar_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  lsb_idx;
    logic              in_conv;

    // Lowest bit position decided for the captured resolution.
    always_comb begin
        lsb_idx = IDX_W'(DATA_W - res_to_bits(8'(res_i)));
        in_conv = (phase_i == PH_CONV);
    end

    // Bit decision and advance to the next trial bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '0;
            idx_q <= IDX_W'(DATA_W - 1);
        end else if (!in_conv) begin
            sar_q <= TOP_CODE;
            idx_q <= IDX_W'(DATA_W - 1);
        end else begin
            if (!cmp_i) begin
                sar_q[idx_q] <= 1'b0;
            end
            if (idx_q != lsb_idx) begin
                sar_q[idx_q - 1'b1] <= 1'b1;
                idx_q               <= idx_q - 1'b1;
            end
        end
    end

    // Final code including the decision of the current bit.
    always_comb begin
        code_o = sar_q;
        if (!cmp_i) begin
            code_o[idx_q] = 1'b0;
        end
    end

    assign dac_o  = in_conv ? sar_q : '0;
    assign last_o = in_conv && (idx_q == lsb_idx);

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_conv && $past(phase_i) != PH_CONV) |-> (dac_o == TOP_CODE)); // R5
    AST_KEEP_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_conv && $past(in_conv) && $past(cmp_i) && !$past(last_o))
        |-> (dac_o[$past(idx_q)] == 1'b1)); // R6

endmodule

// File: rtl/sar_result.sv
// Result register and one-cycle done pulse.
// Assumes last_i is high for a single cycle per conversion.
module sar_result #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_i,
    input  logic [DATA_W-1:0] code_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);

    // Capture the final code and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= last_i;
            if (last_i) begin
                result_o <= code_i;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

endmodule

// File: rtl/sar_conv_seq.sv
// Top of the SAR conversion sequencer: phase control, bit search and
// result register. Assumes cmp_i settles within a cycle of dac_code_o.
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int CH_W    = 4,
    parameter int SMP_W   = 5,
    parameter int RES_W   = 3,
    parameter int BUF_CYC = 2,
    parameter int MIN_SMP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [SMP_W-1:0]  smp_time_i,
    input  logic [RES_W-1:0]  res_sel_i,
    input  logic              cmp_i,
    output logic              busy_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              buf_en_o,
    output logic              direct_en_o,
    output logic              hold_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);

    phase_e            phase;
    logic [RES_W-1:0]  res_q;
    logic              last;
    logic [DATA_W-1:0] final_code;
    logic [DATA_W-1:0] low_mask;

    sar_phase_ctrl #(
        .SMP_W(SMP_W), .RES_W(RES_W), .CH_W(CH_W),
        .BUF_CYC(BUF_CYC), .MIN_SMP(MIN_SMP)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .smp_i(smp_time_i), .res_i(res_sel_i), .last_i(last),
        .phase_o(phase), .busy_o(busy_o), .chan_o(chan_o), .res_o(res_q)
    );

    sar_search #(.DATA_W(DATA_W), .RES_W(RES_W)) u_search (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .res_i(res_q),
        .cmp_i(cmp_i), .dac_o(dac_code_o), .code_o(final_code), .last_o(last)
    );

    sar_result #(.DATA_W(DATA_W)) u_result (
        .clk(clk), .rst_n(rst_n), .last_i(last), .code_i(final_code),
        .result_o(result_o), .done_o(done_o)
    );

    // Decode the phase into the three sample-path enables.
    always_comb begin
        buf_en_o    = (phase == PH_BUF);
        direct_en_o = (phase == PH_DIRECT);
        hold_o      = (phase == PH_CONV);
    end

    // Bits below the captured resolution, for the alignment check.
    always_comb begin
        low_mask = DATA_W'((1 << (DATA_W - res_to_bits(8'(res_q)))) - 1);
    end

    AST_PATHS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_en_o, direct_en_o, hold_o})); // R4
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_RESULT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o & low_mask) == '0)); // R7
    AST_TRIAL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> ((dac_code_o & low_mask) == '0)); // R6

endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  chan = '0;
    logic [4:0]  smp = '0;
    logic [2:0]  res = '0;
    logic        cmp;
    logic        busy, buf_en, dir_en, hold, done;
    logic [3:0]  chan_o;
    logic [11:0] dac, result;
    logic [11:0] cur_vin = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Comparator model: 1 when the input is at or above the trial level.
    assign cmp = (cur_vin >= dac);

    sar_conv_seq u_sar_conv_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
        .smp_time_i(smp), .res_sel_i(res), .cmp_i(cmp),
        .busy_o(busy), .chan_o(chan_o), .buf_en_o(buf_en),
        .direct_en_o(dir_en), .hold_o(hold), .dac_code_o(dac),
        .result_o(result), .done_o(done)
    );

    // Fields: {vin[11:0], smp[4:0], res[2:0], chan[3:0]}
    localparam logic [23:0] VEC [0:7] = '{
        {12'hABC, 5'd4,  3'd2, 4'd3},
        {12'h5A7, 5'd0,  3'd0, 4'd9},
        {12'hFFF, 5'd31, 3'd1, 4'd15},
        {12'h000, 5'd7,  3'd2, 4'd0},
        {12'h800, 5'd3,  3'd1, 4'd6},
        {12'h7FF, 5'd10, 3'd0, 4'd12},
        {12'h123, 5'd5,  3'd7, 4'd1},
        {12'hC3F, 5'd2,  3'd4, 4'd10}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_conv(input logic [11:0] vin, input logic [4:0] s,
                            input logic [2:0] r, input logic [3:0] ch, input bit poke);
        int nbuf = 0, ndir = 0, nhold = 0, cyc = 0;
        int busy_gap = 0, chan_bad = 0, order_bad = 0, dac_bad = 0;
        int exp_n, exp_r;
        bit seen_hold = 0, r1_ok = 0;
        logic [11:0] first_dac = '0;
        logic [11:0] mask;
        exp_n = (s < 4) ? 4 : int'(s);
        exp_r = (r == 3'd0) ? 8 : (r == 3'd1) ? 10 : 12;
        mask  = 12'hFFF << (12 - exp_r);
        cur_vin = vin;
        @(negedge clk);
        start = 1'b1; chan = ch; smp = s; res = r;
        @(negedge clk);
        start = 1'b0; chan = ~ch;
        r1_ok = busy && buf_en;
        while (!done && cyc < 300) begin
            if (buf_en) nbuf++;
            if (dir_en) ndir++;
            if (hold) nhold++;
            if (!busy) busy_gap++;
            if (chan_o != ch) chan_bad++;
            if (int'(buf_en) + int'(dir_en) + int'(hold) > 1) order_bad++;
            if (buf_en && (ndir > 0 || nhold > 0)) order_bad++;
            if (dir_en && nhold > 0) order_bad++;
            if (hold && !seen_hold) begin first_dac = dac; seen_hold = 1; end
            if (!hold && dac != 12'h000) dac_bad++;
            if (hold && (dac & ~mask) != 12'h000) dac_bad++;
            if (poke && cyc == 3) begin
                start = 1'b1; chan = ~ch; smp = 5'd31; res = r + 3'd1;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(r1_ok, "R1 busy+buffer after start", int'(r1_ok), 1);
        chk(nbuf == 2, "R2 buffered cycles", nbuf, 2);
        chk(ndir == exp_n - 2, "R3 direct cycles", ndir, exp_n - 2);
        chk(order_bad == 0, "R4 enable order/exclusive", order_bad, 0);
        chk(nhold == exp_r, "R5 hold cycles", nhold, exp_r);
        chk(cyc == exp_n + exp_r, "R5 latency", cyc, exp_n + exp_r);
        chk(first_dac == 12'h800, "R5 first trial", int'(first_dac), 12'h800);
        chk(dac_bad == 0, "R6 trial code range", dac_bad, 0);
        chk(result == (vin & mask), "R6 R7 result", int'(result), int'(vin & mask));
        chk(done && !busy, "R8 busy low at done", int'(busy), 0);
        chk(busy_gap == 0, "R8 busy gaps", busy_gap, 0);
        chk(chan_bad == 0, "R9 channel held", chan_bad, 0);
        @(negedge clk);
        chk(!done, "R7 done single cycle", int'(done), 0);
        chk(!busy, "R8 no restart after ignored start", int'(busy), 0);
    endtask

    task automatic chk_reset_state(input string tag);
        chk(!busy && !done && !buf_en && !dir_en && !hold,
            tag, int'({busy, done, buf_en, dir_en, hold}), 0);
        chk(dac == 12'h000 && result == 12'h000, tag, int'(dac | result), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk_reset_state("R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            run_conv(VEC[i][23:12], VEC[i][11:7], VEC[i][6:4], VEC[i][3:0],
                     (i == 2) || (i == 5));
        end
        // R10: reset in the middle of a conversion.
        cur_vin = 12'hFFF;
        @(negedge clk);
        start = 1'b1; chan = 4'd5; smp = 5'd4; res = 3'd2;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(hold, "R10 in hold before reset", int'(hold), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state("R10 reset mid-conversion");
        rst_n = 1'b1;
        @(negedge clk);
        run_conv(12'h3C5, 5'd6, 3'd1, 4'd7, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule